// File: doc/BRIEF.md
# Inversion-Coded Link Receive Decoder

This block sits at the receiving end of an on-chip link whose transmitter may invert part of each flit to cut wire switching activity. Each link word holds one inversion indicator plus the data lines. The decoder reads the indicator and undoes the transmitter's optional inversion of the odd-numbered data lines. An optional Gray-to-binary stage then recovers the original value. The result is registered and presented one cycle later together with a valid flag.

The output register always holds the most recently decoded flit. The restoration path feeds this register back, so cycles without a valid word leave the decoded value unchanged. A parameter selects whether the Gray conversion is built. With it switched off, the block returns the inversion-free link data as it is. Only the odd/no-inversion variant is handled, so the indicator is a single bit with no ambiguity. The asynchronous reset is released synchronously inside the block.

Top module: `inv_link_decoder`

## Requirements
- R1: While reset is active, and on the first cycles after a reset, `flit_o` reads zero and `flit_vld_o` reads 0.
- R2: The link word carries data in bits [LINK_W-2:0] and the inversion indicator in bit LINK_W-1. The recovered flit is LINK_W-1 bits wide.
- R3: An indicator of 0 means the data bits are taken as they are, with no bit flipped, before the optional Gray stage.
- R4: An indicator of 1 flips every data bit at an odd index (1, 3, 5, ...) and leaves the even-index bits unchanged.
- R5: With USE_GRAY=1, the inversion-free word g is converted as b[msb]=g[msb] and b[i]=b[i+1] XOR g[i], working down to bit 0.
- R6: With USE_GRAY=0, the Gray stage is absent and the inversion-free word appears on `flit_o` unchanged.
- R7: `flit_vld_o` in a cycle equals `link_vld_i` of the cycle before. A word accepted at one clock edge is visible on `flit_o` right after that edge.
- R8: When `link_vld_i` is 0, the link word is ignored and `flit_o` keeps the last decoded value.
- R9: A transmitter that Gray-codes a binary flit and then chooses freely between odd inversion and no inversion, with the matching indicator, has its flit returned unchanged on `flit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_vld_i | input | 1 | Link word is valid this cycle |
| link_word_i | input | LINK_W | Indicator in the top bit, data lines below it |
| flit_o | output | LINK_W-1 | Decoded flit (held while idle) |
| flit_vld_o | output | 1 | Decoded flit updated this cycle |

## Verification
Every data value of a 6-bit configuration is applied with each indicator value. A build with the Gray stage and one without it run side by side, which separates a wrong inversion mask from a wrong Gray chain and shows which bit positions are affected. A lone all-zero word with the indicator set exposes the mask shape directly. Idle cycles that carry changing link data check that the held value does not move. A long pseudo-random stream from a model transmitter that picks the inversion to reduce toggles checks the full round trip, and a reset in the middle of the run checks that the output returns to zero.

// File: rtl/inv_link_decoder_pkg.sv
package inv_link_decoder_pkg;
  // Polarity marker carried on the top line of each link word.
  typedef enum logic {
    POL_PLAIN = 1'b0,
    POL_ODD   = 1'b1
  } lnk_pol_e;

  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/inv_link_decoder_rst_sync.sv
module inv_link_decoder_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/inv_link_decoder_unmask.sv
module inv_link_decoder_unmask #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         flip_i,
  output logic [W-1:0] data_o
);
  // Odd-indexed lanes pass through an XOR driven by the polarity flag.
  for (genvar i = 0; i < W; i++) begin : g_lane
    if ((i % 2) == 1) begin : g_odd
      assign data_o[i] = data_i[i] ^ flip_i;
    end else begin : g_even
      assign data_o[i] = data_i[i];
    end
  end
endmodule

// File: rtl/inv_link_decoder_gray2bin.sv
module inv_link_decoder_gray2bin #(
  parameter int unsigned W        = 8,
  parameter bit          USE_GRAY = 1'b1
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  if (USE_GRAY) begin : g_conv
    logic acc;
    always_comb begin
      acc   = 1'b0;
      bin_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
        acc      = acc ^ gray_i[i];
        bin_o[i] = acc;
      end
    end
  end else begin : g_bypass
    assign bin_o = gray_i;
  end
endmodule

// File: rtl/inv_link_decoder_hold.sv
module inv_link_decoder_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  logic [W-1:0] q_q, q_d;
  logic         vld_q, vld_d;

  // Previous decoded word is fed back; it is replaced only on a valid word.
  always_comb begin
    q_d   = q_q;
    vld_d = load_i;
    if (load_i) begin
      q_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      q_q   <= q_d;
      vld_q <= vld_d;
    end
  end

  assign q_o   = q_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/inv_link_decoder.sv
module inv_link_decoder
  import inv_link_decoder_pkg::*;
#(
  parameter int unsigned LINK_W   = 9,
  parameter bit          USE_GRAY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_vld_i,
  input  logic [LINK_W-1:0] link_word_i,
  output logic [LINK_W-2:0] flit_o,
  output logic              flit_vld_o
);
  localparam int unsigned FLIT_W  = LINK_W - 1;
  localparam int unsigned POL_BIT = LINK_W - 1;

  logic              rst_core_n;
  lnk_pol_e          pol;
  logic [FLIT_W-1:0] plain_data;
  logic [FLIT_W-1:0] bin_data;

  inv_link_decoder_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  assign pol = lnk_pol_e'(link_word_i[POL_BIT]);

  inv_link_decoder_unmask #(
    .W(FLIT_W)
  ) u_unmask (
    .data_i(link_word_i[FLIT_W-1:0]),
    .flip_i(pol == POL_ODD),
    .data_o(plain_data)
  );

  inv_link_decoder_gray2bin #(
    .W       (FLIT_W),
    .USE_GRAY(USE_GRAY)
  ) u_g2b (
    .gray_i(plain_data),
    .bin_o (bin_data)
  );

  inv_link_decoder_hold #(
    .W(FLIT_W)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load_i(link_vld_i),
    .d_i   (bin_data),
    .q_o   (flit_o),
    .vld_o (flit_vld_o)
  );
endmodule

// File: rtl/inv_link_decoder_chk.sv
module inv_link_decoder_chk #(
  parameter int unsigned LINK_W   = 9,
  parameter bit          USE_GRAY = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [LINK_W-1:0] in_word,
  input logic [LINK_W-2:0] flit,
  input logic              flit_vld
);
  localparam int unsigned FW = LINK_W - 1;

  logic [FW-1:0] odd_sel;
  logic [FW-1:0] wire_view;
  logic [FW-1:0] reenc;

  always_comb begin
    for (int i = 0; i < FW; i++) begin
      odd_sel[i] = ((i % 2) == 1);
    end
  end

  // What the data lines would carry without inversion.
  assign wire_view = in_word[FW-1:0] ^ (in_word[LINK_W-1] ? odd_sel : '0);
  // Re-encode the decoded output back toward the wire domain.
  assign reenc = USE_GRAY ? (flit ^ (flit >> 1)) : flit;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (flit == '0 && flit_vld == 1'b0); // R1
    end
  end

  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> flit_vld); // R7

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !flit_vld); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(flit)); // R8

  AST_RESTORE_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> reenc == $past(wire_view)); // R4
endmodule

bind inv_link_decoder inv_link_decoder_chk #(
  .LINK_W  (LINK_W),
  .USE_GRAY(USE_GRAY)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .in_vld  (link_vld_i),
  .in_word (link_word_i),
  .flit    (flit_o),
  .flit_vld(flit_vld_o)
);

// File: tb/inv_link_decoder_tb.sv
module inv_link_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 7;
  localparam int FW = LW - 1;
  localparam logic [FW-1:0] ODD_M = 6'b101010;

  logic          clk;
  logic          rst_n;
  logic          vld;
  logic [LW-1:0] word;
  logic [FW-1:0] flit_g, flit_r;
  logic          vld_g, vld_r;

  int total;
  int bad;
  bit done;

  inv_link_decoder #(.LINK_W(LW), .USE_GRAY(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_vld_i(vld), .link_word_i(word),
    .flit_o(flit_g), .flit_vld_o(vld_g)
  );

  inv_link_decoder #(.LINK_W(LW), .USE_GRAY(1'b0)) u_dut_raw (
    .clk(clk), .rst_n(rst_n), .link_vld_i(vld), .link_word_i(word),
    .flit_o(flit_r), .flit_vld_o(vld_r)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [FW-1:0] g2b(input logic [FW-1:0] g);
    logic [FW-1:0] b;
    b[FW-1] = g[FW-1];
    for (int i = FW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [LW-1:0] w);
    vld  = v;
    word = w;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vld   = 1'b0;
    word  = '0;
    repeat (3) @(negedge clk);
    chk("R1 flit in reset", flit_g, '0);
    chk("R1 valid in reset", {5'd0, vld_g}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flit after release", flit_g, '0);
    chk("R1 valid after release", {5'd0, vld_r}, '0);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    vld   = 1'b0;
    word  = '0;
    @(negedge clk);
    do_reset();

    // Exhaustive sweep over data and indicator (R2, R3, R4, R5, R6, R7).
    for (int inv = 0; inv < 2; inv++) begin
      for (int v = 0; v < (1 << FW); v++) begin
        logic [FW-1:0] d;
        logic [FW-1:0] plain;
        d     = FW'(v);
        plain = d ^ (inv != 0 ? ODD_M : '0);
        apply(1'b1, {inv[0], d});
        chk(inv != 0 ? "R4 R5 gray build" : "R3 R5 gray build", flit_g, g2b(plain));
        chk(inv != 0 ? "R4 R6 raw build" : "R3 R6 raw build", flit_r, plain);
        chk("R7 valid after word", {5'd0, vld_g & vld_r}, 6'd1);
      end
    end

    // Mask shape: all-zero data with indicator set (R4, R2).
    apply(1'b1, {1'b1, 6'd0});
    chk("R4 mask shape", flit_r, ODD_M);
    apply(1'b1, {1'b0, 6'h3f});
    chk("R2 indicator clear", flit_r, 6'h3f);

    // Idle cycles with changing data (R8, R7).
    apply(1'b1, {1'b0, 6'h2d});
    chk("R5 load before idle", flit_g, g2b(6'h2d));
    for (int k = 0; k < 6; k++) begin
      apply(1'b0, {k[0], 6'(k * 11 + 3)});
      chk("R8 gray hold", flit_g, g2b(6'h2d));
      chk("R8 raw hold", flit_r, 6'h2d);
      chk("R7 idle valid", {5'd0, vld_g | vld_r}, 6'd0);
    end

    // Round trip from a model transmitter (R9).
    begin
      logic [FW-1:0] prev_wire;
      logic [15:0]   seed;
      prev_wire = '0;
      seed      = 16'hace1;
      for (int n = 0; n < 400; n++) begin
        logic [FW-1:0] bin, gw, cand;
        logic          inv;
        seed = seed * 16'd25173 + 16'd13849;
        bin  = seed[13:8];
        gw   = bin ^ (bin >> 1);
        cand = gw ^ ODD_M;
        inv  = $countones(cand ^ prev_wire) < $countones(gw ^ prev_wire);
        if (n % 7 == 3) inv = ~inv;
        prev_wire = inv ? cand : gw;
        apply(1'b1, {inv, prev_wire});
        chk("R9 round trip", flit_g, bin);
        chk("R9 raw returns gray", flit_r, gw);
        if (n % 9 == 4) begin
          apply(1'b0, {~inv, ~prev_wire});
          chk("R8 hold in stream", flit_g, bin);
        end
      end
    end

    // Reset in the middle of traffic (R1).
    apply(1'b1, {1'b0, 6'h15});
    do_reset();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule